// File: doc/BRIEF.md
# Non-Blocking Prefetch Queue with Shared-Bus Arbiter

This block sits between a set of processors and one shared memory bus. Every processor owns a small queue of outstanding prefetches, so it keeps running while they are serviced. It is held back only when its queue has no free slot. A single arbiter hands the bus to one queue at a time. Demand loads win over prefetches, and a rotating pointer keeps each class fair among processors.

A granted transaction keeps the data bus busy for a programmable number of cycles, the transfer window. The response comes back a fixed total latency after the grant. The rest of that latency is not contended, so several transactions can be in flight at once. A demand load that names a line already known to its own queue creates no second request. If the line is still queued, that entry is raised to demand priority. If the line is already on the bus, the load waits for that response. Response beats carry the processor number and the line address, and these retire the matching queue entry.

Top module: `pfq_top`

## Requirements
- R1: After reset no grant and no response is presented, every `pf_ready` bit is 1 and every `ld_busy` bit is 0.
- R2: A processor's `pf_ready` is 0 exactly while all DEPTH prefetch slots of its queue are occupied. An entry occupies a slot from acceptance until its response. A prefetch offered while `pf_ready` is 0 is not taken and is never granted.
- R3: A prefetch whose address equals an entry already held in the same processor's queue is dropped. This applies whether that entry is waiting or in flight, and the line is granted only once.
- R4: After a grant, the next grant comes no sooner than T cycles later. T is `xfer_cycles` clamped to the range XFER_MIN..XFER_MAX. With requests waiting continuously, the next grant comes exactly T cycles later.
- R5: Every grant produces exactly one response, exactly TOTAL_LAT cycles after the grant cycle. The response carries the granted processor number and line address.
- R6: When the bus is free and any processor has a waiting demand request, the grant goes to a demand request (`gnt_demand` = 1) rather than to a prefetch.
- R7: Within each class the arbiter rotates. After a processor is granted, the other processors of that class rank ahead of it. Two processors with prefetches waiting receive alternating grants.
- R8: A demand load whose line is waiting, not yet granted, in its own queue promotes that entry. The entry's grant carries `gnt_demand` = 1 and comes ahead of older prefetches.
- R9: A demand load whose line is already in flight for that processor issues no new grant. `ld_done` pulses for one cycle in the cycle after that line's response.
- R10: A demand load that matches no entry raises `ld_busy` in the next cycle and is granted as a demand request. `ld_done` pulses in the cycle after its response, and `ld_busy` then falls.
- R11: A load presented while that processor's `ld_busy` is 1 is ignored. It creates no grant and no extra `ld_done`.
- R12: A load for a line whose response for that processor is presented in the same cycle completes at once. `ld_done` pulses in the next cycle, `ld_busy` stays 0 and no new grant is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_cycles | input | XW | Requested bus transfer window in cycles, clamped internally |
| pf_valid | input | N_CPU | Prefetch offer per processor |
| pf_addr | input | N_CPU*AW | Prefetch line address per processor |
| pf_ready | output | N_CPU | Prefetch queue has a free slot |
| ld_valid | input | N_CPU | Demand load start per processor |
| ld_addr | input | N_CPU*AW | Demand load line address per processor |
| ld_busy | output | N_CPU | Demand load outstanding (processor stalled) |
| ld_done | output | N_CPU | One-cycle demand completion pulse |
| gnt_valid | output | 1 | Bus granted this cycle |
| gnt_cpu | output | CW | Granted processor |
| gnt_addr | output | AW | Granted line address |
| gnt_demand | output | 1 | Grant is a demand request |
| bus_busy | output | 1 | Data transfer window occupied |
| rsp_valid | output | 1 | Response beat |
| rsp_cpu | output | CW | Processor owning the response |
| rsp_addr | output | AW | Line address of the response |

## Verification
The bench builds the block with two processors, four prefetch slots, 8-bit line addresses, a 20-cycle total latency and a transfer window clamped to 4..8. With a queue that small, the full stall and the rejection of extra offers are reached in a handful of cycles. A sweep of the requested window from 2 to 10 covers every clamped and unclamped setting. The short latency makes it quick to line up the cases that depend on exact cycles. These include promotion before a grant, a load merging with a line in flight, and a load arriving together with its own response.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic {
    CLS_PREFETCH = 1'b0,
    CLS_DEMAND   = 1'b1
  } req_class_e;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/pfq_rr_pick.sv
module pfq_rr_pick #(
  parameter  int N  = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          found,
  output logic [CW-1:0] idx
);

  logic [CW-1:0] ptr_q, ptr_d;

  // search starting at the pointer, wrapping once
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= N) j = j - N;
      if (!found && req[j]) begin
        found = 1'b1;
        idx   = CW'(j);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      if (int'(idx) == N - 1) ptr_d = '0;
      else                    ptr_d = idx + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

endmodule

// File: rtl/pfq_arbiter.sv
module pfq_arbiter
  import pfq_pkg::*;
#(
  parameter  int N  = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_dem,
  input  logic [N-1:0]  req_pf,
  input  logic          bus_free,
  output logic [N-1:0]  gnt_oh,
  output logic          gnt_valid,
  output req_class_e    gnt_cls,
  output logic [CW-1:0] gnt_idx
);

  logic [1:0]    cls_found;
  logic [1:0]    cls_adv;
  logic [CW-1:0] cls_idx [2];
  logic [N-1:0]  cls_req [2];

  assign cls_req[0] = req_pf;
  assign cls_req[1] = req_dem;

  // one rotating picker per request class
  for (genvar g = 0; g < 2; g++) begin : g_class
    pfq_rr_pick #(.N(N)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (cls_req[g]),
      .adv   (cls_adv[g]),
      .found (cls_found[g]),
      .idx   (cls_idx[g])
    );
  end

  always_comb begin
    gnt_cls   = cls_found[1] ? CLS_DEMAND : CLS_PREFETCH;
    gnt_valid = bus_free && (|cls_found);
    gnt_idx   = cls_found[1] ? cls_idx[1] : cls_idx[0];
    cls_adv[1] = gnt_valid && cls_found[1];
    cls_adv[0] = gnt_valid && !cls_found[1];
    gnt_oh    = '0;
    if (gnt_valid) gnt_oh[gnt_idx] = 1'b1;
  end

endmodule

// File: rtl/pfq_buffer.sv
module pfq_buffer #(
  parameter int AW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pf_valid,
  input  logic [AW-1:0] pf_addr,
  output logic          pf_ready,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_busy,
  output logic          ld_done,
  output logic          req_dem,
  output logic          req_pf,
  input  logic          grant,
  output logic [AW-1:0] issue_addr,
  input  logic          rsp_mine,
  input  logic [AW-1:0] rsp_addr
);

  localparam int E     = DEPTH + 1;   // prefetch slots plus one demand slot
  localparam int DSLOT = DEPTH;
  localparam int IW    = $clog2(E);

  logic [E-1:0]  v_q, iss_q, dem_q;
  logic [E-1:0]  v_d, iss_d, dem_d;
  logic [E-1:0]  addr_we;
  logic [AW-1:0] addr_q [E];
  logic          done_d, done_q;

  logic [E-1:0]  m_rsp, m_ld, m_pf, free_pf, wait_dem, wait_pf;
  logic [IW-1:0] dem_idx, pf_idx, alloc_idx, sel_idx;
  logic          ld_take, ld_alloc, pf_take;

  always_comb begin
    for (int i = 0; i < E; i++) begin
      m_rsp[i]    = rsp_mine && v_q[i] && iss_q[i] && (addr_q[i] == rsp_addr);
      m_ld[i]     = v_q[i] && (addr_q[i] == ld_addr);
      m_pf[i]     = v_q[i] && (addr_q[i] == pf_addr);
      free_pf[i]  = (i < DEPTH) && !v_q[i];
      wait_dem[i] = v_q[i] && dem_q[i] && !iss_q[i];
      wait_pf[i]  = v_q[i] && !dem_q[i] && !iss_q[i];
    end
  end

  // lowest-index encoders
  always_comb begin
    dem_idx   = '0;
    pf_idx    = '0;
    alloc_idx = '0;
    for (int i = E - 1; i >= 0; i--) begin
      if (wait_dem[i]) dem_idx   = IW'(i);
      if (wait_pf[i])  pf_idx    = IW'(i);
      if (free_pf[i])  alloc_idx = IW'(i);
    end
  end

  assign pf_ready   = |free_pf;
  assign ld_busy    = |(v_q & dem_q);
  assign req_dem    = |wait_dem;
  assign req_pf     = |wait_pf;
  assign sel_idx    = req_dem ? dem_idx : pf_idx;
  assign issue_addr = addr_q[sel_idx];
  assign ld_done    = done_q;

  assign ld_take  = ld_valid && !ld_busy;
  assign ld_alloc = ld_take && !(|m_ld);
  assign pf_take  = pf_valid && pf_ready && !(|m_pf) &&
                    !(ld_alloc && (ld_addr == pf_addr));

  // next state: retire, issue, demand merge/alloc, prefetch enqueue
  always_comb begin
    v_d     = v_q;
    iss_d   = iss_q;
    dem_d   = dem_q;
    addr_we = '0;
    done_d  = 1'b0;
    for (int i = 0; i < E; i++) begin
      if (m_rsp[i]) begin
        v_d[i]   = 1'b0;
        iss_d[i] = 1'b0;
        dem_d[i] = 1'b0;
        if (dem_q[i]) done_d = 1'b1;
      end
    end
    if (grant) iss_d[sel_idx] = 1'b1;
    if (ld_take) begin
      if (|(m_ld & m_rsp)) begin
        done_d = 1'b1;
      end else if (|m_ld) begin
        dem_d = dem_d | m_ld;
      end else begin
        v_d[DSLOT]     = 1'b1;
        iss_d[DSLOT]   = 1'b0;
        dem_d[DSLOT]   = 1'b1;
        addr_we[DSLOT] = 1'b1;
      end
    end
    if (pf_take) begin
      v_d[alloc_idx]     = 1'b1;
      iss_d[alloc_idx]   = 1'b0;
      dem_d[alloc_idx]   = 1'b0;
      addr_we[alloc_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      iss_q  <= '0;
      dem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      v_q    <= v_d;
      iss_q  <= iss_d;
      dem_q  <= dem_d;
      done_q <= done_d;
    end
  end

  for (genvar i = 0; i < E; i++) begin : g_addr
    always_ff @(posedge clk) begin
      if (addr_we[i]) addr_q[i] <= (i == DSLOT) ? ld_addr : pf_addr;
    end
  end

endmodule

// File: rtl/pfq_flight.sv
module pfq_flight #(
  parameter int N         = 4,
  parameter int AW        = 16,
  parameter int TOTAL_LAT = 100,
  parameter int SLOTS     = 26,
  parameter int CW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [CW-1:0] push_cpu,
  input  logic [AW-1:0] push_addr,
  output logic          rsp_valid,
  output logic [CW-1:0] rsp_cpu,
  output logic [AW-1:0] rsp_addr
);

  localparam int TW = $clog2(TOTAL_LAT + 1) + 1;
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int NW = $clog2(SLOTS + 1);

  logic [TW-1:0] now_q;
  logic [TW-1:0] stamp_q [SLOTS];
  logic [CW-1:0] cpu_q   [SLOTS];
  logic [AW-1:0] addr_q  [SLOTS];
  logic [PW-1:0] head_q, tail_q, head_d, tail_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          pop;

  // grants are spaced, so completions leave in grant order
  assign rsp_valid = (cnt_q != '0) &&
                     ((now_q - stamp_q[head_q]) == TW'(TOTAL_LAT));
  assign rsp_cpu   = cpu_q[head_q];
  assign rsp_addr  = addr_q[head_q];
  assign pop       = rsp_valid;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (pop)  head_d = (int'(head_q) == SLOTS - 1) ? '0 : head_q + PW'(1);
    if (push) tail_d = (int'(tail_q) == SLOTS - 1) ? '0 : tail_q + PW'(1);
    if (push && !pop)      cnt_d = cnt_q + NW'(1);
    else if (!push && pop) cnt_d = cnt_q - NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      now_q  <= now_q + TW'(1);
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      stamp_q[tail_q] <= now_q;
      cpu_q[tail_q]   <= push_cpu;
      addr_q[tail_q]  <= push_addr;
    end
  end

endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter  int N_CPU     = 4,
  parameter  int AW        = 16,
  parameter  int DEPTH     = 16,
  parameter  int TOTAL_LAT = 100,
  parameter  int XFER_MIN  = 4,
  parameter  int XFER_MAX  = 32,
  localparam int CW        = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int XW        = $clog2(XFER_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [XW-1:0]       xfer_cycles,
  input  logic [N_CPU-1:0]    pf_valid,
  input  logic [N_CPU*AW-1:0] pf_addr,
  output logic [N_CPU-1:0]    pf_ready,
  input  logic [N_CPU-1:0]    ld_valid,
  input  logic [N_CPU*AW-1:0] ld_addr,
  output logic [N_CPU-1:0]    ld_busy,
  output logic [N_CPU-1:0]    ld_done,
  output logic                gnt_valid,
  output logic [CW-1:0]       gnt_cpu,
  output logic [AW-1:0]       gnt_addr,
  output logic                gnt_demand,
  output logic                bus_busy,
  output logic                rsp_valid,
  output logic [CW-1:0]       rsp_cpu,
  output logic [AW-1:0]       rsp_addr
);

  localparam int FSLOTS = TOTAL_LAT / XFER_MIN + 1;

  logic [N_CPU-1:0] req_dem, req_pf, gnt_oh;
  logic [AW-1:0]    issue_addr [N_CPU];
  logic [CW-1:0]    gnt_idx;
  req_class_e       gnt_cls;
  logic [XW-1:0]    xfer_eff;
  logic [XW-1:0]    bus_cnt_q, bus_cnt_d;
  logic             bus_free, bus_en;

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    pfq_buffer #(.AW(AW), .DEPTH(DEPTH)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .pf_valid   (pf_valid[c]),
      .pf_addr    (pf_addr[c*AW +: AW]),
      .pf_ready   (pf_ready[c]),
      .ld_valid   (ld_valid[c]),
      .ld_addr    (ld_addr[c*AW +: AW]),
      .ld_busy    (ld_busy[c]),
      .ld_done    (ld_done[c]),
      .req_dem    (req_dem[c]),
      .req_pf     (req_pf[c]),
      .grant      (gnt_oh[c]),
      .issue_addr (issue_addr[c]),
      .rsp_mine   (rsp_valid && (rsp_cpu == CW'(c))),
      .rsp_addr   (rsp_addr)
    );
  end

  pfq_arbiter #(.N(N_CPU)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_dem   (req_dem),
    .req_pf    (req_pf),
    .bus_free  (bus_free),
    .gnt_oh    (gnt_oh),
    .gnt_valid (gnt_valid),
    .gnt_cls   (gnt_cls),
    .gnt_idx   (gnt_idx)
  );

  pfq_flight #(
    .N(N_CPU), .AW(AW), .TOTAL_LAT(TOTAL_LAT), .SLOTS(FSLOTS), .CW(CW)
  ) u_flight (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (gnt_valid),
    .push_cpu  (gnt_idx),
    .push_addr (gnt_addr),
    .rsp_valid (rsp_valid),
    .rsp_cpu   (rsp_cpu),
    .rsp_addr  (rsp_addr)
  );

  assign gnt_cpu    = gnt_idx;
  assign gnt_addr   = issue_addr[gnt_idx];
  assign gnt_demand = gnt_valid && (gnt_cls == CLS_DEMAND);

  // contended data-transfer window
  assign xfer_eff = XW'(clamp_int(int'(xfer_cycles), XFER_MIN, XFER_MAX));
  assign bus_free = (bus_cnt_q == '0);
  assign bus_busy = !bus_free;
  assign bus_en   = gnt_valid || !bus_free;

  always_comb begin
    if (gnt_valid) bus_cnt_d = xfer_eff - XW'(1);
    else           bus_cnt_d = bus_cnt_q - XW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_cnt_q <= '0;
    else if (bus_en) bus_cnt_q <= bus_cnt_d;
  end

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int N_CPU    = 4,
  parameter int XFER_MIN = 4,
  parameter int XFER_MAX = 32,
  parameter int XW       = 6,
  parameter int CW       = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [XW-1:0]    xfer_cycles,
  input logic             gnt_valid,
  input logic             gnt_demand,
  input logic [N_CPU-1:0] gnt_oh,
  input logic [N_CPU-1:0] req_dem,
  input logic             rsp_valid,
  input logic [CW-1:0]    rsp_cpu,
  input logic [N_CPU-1:0] ld_done
);

  logic [7:0] since_q;
  logic [7:0] open_q;
  int         want;

  always_comb begin
    want = int'(xfer_cycles);
    if (want < XFER_MIN) want = XFER_MIN;
    if (want > XFER_MAX) want = XFER_MAX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= 8'hFF;
      open_q  <= '0;
    end else begin
      if (gnt_valid)            since_q <= 8'd1;
      else if (since_q != 8'hFF) since_q <= since_q + 8'd1;
      open_q <= open_q + {7'd0, gnt_valid} - {7'd0, rsp_valid};
    end
  end

  assert_xfer_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (int'(since_q) >= want));

  assert_demand_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_demand) |-> (req_dem == '0));

  assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_oh));

  assert_rsp_has_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (open_q != '0));

  for (genvar c = 0; c < N_CPU; c++) begin : g_done
    assert_done_after_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done[c] |-> ($past(rsp_valid) && ($past(rsp_cpu) == CW'(c))));
  end

endmodule

bind pfq_top pfq_checker #(
  .N_CPU(N_CPU), .XFER_MIN(XFER_MIN), .XFER_MAX(XFER_MAX), .XW(XW), .CW(CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_cycles (xfer_cycles),
  .gnt_valid   (gnt_valid),
  .gnt_demand  (gnt_demand),
  .gnt_oh      (gnt_oh),
  .req_dem     (req_dem),
  .rsp_valid   (rsp_valid),
  .rsp_cpu     (rsp_cpu),
  .ld_done     (ld_done)
);

// File: tb/sim_pfq_top.sv
module sim_pfq_top;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 2;
  localparam int AW    = 8;
  localparam int DEPTH = 4;
  localparam int TOTAL = 20;
  localparam int XMIN  = 4;
  localparam int XMAX  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    xfer_cycles = 4'd8;
  logic [N-1:0]  pf_valid = '0;
  logic [N*AW-1:0] pf_addr = '0;
  logic [N-1:0]  pf_ready;
  logic [N-1:0]  ld_valid = '0;
  logic [N*AW-1:0] ld_addr = '0;
  logic [N-1:0]  ld_busy, ld_done;
  logic          gnt_valid, gnt_demand, bus_busy, rsp_valid;
  logic [0:0]    gnt_cpu, rsp_cpu;
  logic [AW-1:0] gnt_addr, rsp_addr;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  int gtime [N][256];
  int gcnt  [N][256];
  int glog_cpu [64];
  int glog_addr[64];
  int glog_dem [64];
  int glog_cyc [64];
  int gn = 0;
  int done_cyc [N];
  int done_cnt [N];

  pfq_top #(
    .N_CPU(N), .AW(AW), .DEPTH(DEPTH), .TOTAL_LAT(TOTAL),
    .XFER_MIN(XMIN), .XFER_MAX(XMAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .xfer_cycles(xfer_cycles),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_busy(ld_busy), .ld_done(ld_done),
    .gnt_valid(gnt_valid), .gnt_cpu(gnt_cpu), .gnt_addr(gnt_addr),
    .gnt_demand(gnt_demand), .bus_busy(bus_busy),
    .rsp_valid(rsp_valid), .rsp_cpu(rsp_cpu), .rsp_addr(rsp_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampx(input int x);
    if (x < XMIN) return XMIN;
    if (x > XMAX) return XMAX;
    return x;
  endfunction

  initial begin
    for (int c = 0; c < N; c++) begin
      done_cyc[c] = -1;
      done_cnt[c] = 0;
      for (int a = 0; a < 256; a++) begin
        gtime[c][a] = -1000;
        gcnt[c][a]  = 0;
      end
    end
  end

  // observer, sampling away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (gnt_valid) begin
        gtime[gnt_cpu][gnt_addr] = cyc;
        gcnt[gnt_cpu][gnt_addr]  = gcnt[gnt_cpu][gnt_addr] + 1;
        if (gn < 64) begin
          glog_cpu[gn]  = int'(gnt_cpu);
          glog_addr[gn] = int'(gnt_addr);
          glog_dem[gn]  = int'(gnt_demand);
          glog_cyc[gn]  = cyc;
        end
        gn++;
      end
      if (rsp_valid) begin
        chk(gcnt[rsp_cpu][rsp_addr] > 0, "R5 response without grant",
            gcnt[rsp_cpu][rsp_addr], 1);
        chk(cyc - gtime[rsp_cpu][rsp_addr] == TOTAL, "R5 response latency",
            cyc - gtime[rsp_cpu][rsp_addr], TOTAL);
      end
      for (int c = 0; c < N; c++) begin
        if (ld_done[c]) begin
          done_cyc[c] = cyc;
          done_cnt[c]++;
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) tick();
  endtask

  task automatic push_pf(input int c, input int a);
    pf_valid[c] = 1'b1;
    pf_addr[c*AW +: AW] = AW'(a);
    tick();
    pf_valid[c] = 1'b0;
  endtask

  task automatic push_pf2(input int a0, input int a1);
    pf_valid = '1;
    pf_addr[0 +: AW]  = AW'(a0);
    pf_addr[AW +: AW] = AW'(a1);
    tick();
    pf_valid = '0;
  endtask

  task automatic push_ld(input int c, input int a);
    ld_valid[c] = 1'b1;
    ld_addr[c*AW +: AW] = AW'(a);
    tick();
    ld_valid[c] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int d0;
    bool_found: begin end
    wait_n(3);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk(pf_ready == 2'b11, "R1 pf_ready", int'(pf_ready), 3);
    chk(ld_busy == 2'b00, "R1 ld_busy", int'(ld_busy), 0);
    chk(!gnt_valid && !rsp_valid, "R1 idle bus", int'({gnt_valid, rsp_valid}), 0);

    // R4 transfer window sweep, clamped and unclamped
    for (int x = 2; x <= 10; x++) begin
      int base;
      base = 150 + 3 * (x - 2);
      xfer_cycles = 4'(x);
      gn = 0;
      push_pf(0, base);
      push_pf(0, base + 1);
      push_pf(0, base + 2);
      wait_n(3 * XMAX + TOTAL + 4);
      chk(gn == 3, "R5 grant count in sweep", gn, 3);
      chk(glog_cyc[1] - glog_cyc[0] == clampx(x), "R4 grant spacing 1",
          glog_cyc[1] - glog_cyc[0], clampx(x));
      chk(glog_cyc[2] - glog_cyc[1] == clampx(x), "R4 grant spacing 2",
          glog_cyc[2] - glog_cyc[1], clampx(x));
    end

    // R2 full queue stalls and rejects
    xfer_cycles = 4'd8;
    gn = 0;
    push_pf(0, 1);
    push_pf(0, 2);
    push_pf(0, 3);
    push_pf(0, 4);
    chk(pf_ready[0] == 1'b0, "R2 full queue not ready", int'(pf_ready[0]), 0);
    chk(pf_ready[1] == 1'b1, "R2 other queue ready", int'(pf_ready[1]), 1);
    push_pf(0, 5);
    wait_n(60);
    chk(gcnt[0][5] == 0, "R2 offer while full granted", gcnt[0][5], 0);
    chk(pf_ready[0] == 1'b1, "R2 ready after drain", int'(pf_ready[0]), 1);
    chk(gn == 4, "R2 grants for full queue", gn, 4);

    // R3 duplicates, queued and in flight
    gn = 0;
    push_pf(1, 40);
    push_pf(1, 40);
    wait_n(3);
    push_pf(1, 40);
    wait_n(30);
    chk(gcnt[1][40] == 1, "R3 duplicate line granted", gcnt[1][40], 1);

    // R7 rotation between two processors
    xfer_cycles = 4'd4;
    gn = 0;
    push_pf2(50, 60);
    push_pf2(51, 61);
    wait_n(40);
    chk(gn == 4, "R7 grant count", gn, 4);
    for (int i = 0; i < 3; i++)
      chk(glog_cpu[i] != glog_cpu[i+1], "R7 alternation", glog_cpu[i+1], 1 - glog_cpu[i]);

    // R6 and R10 demand miss wins over waiting prefetches
    xfer_cycles = 4'd8;
    gn = 0;
    d0 = done_cnt[1];
    push_pf(0, 70);
    push_pf(0, 71);
    push_pf(0, 72);
    push_ld(1, 90);
    chk(ld_busy[1] == 1'b1, "R10 busy after miss", int'(ld_busy[1]), 1);
    wait_n(60);
    chk(glog_cpu[1] == 1 && glog_addr[1] == 90, "R6 demand granted next",
        glog_addr[1], 90);
    chk(glog_dem[1] == 1, "R10 demand class flag", glog_dem[1], 1);
    chk(done_cyc[1] == gtime[1][90] + TOTAL + 1, "R10 done timing",
        done_cyc[1], gtime[1][90] + TOTAL + 1);
    chk(done_cnt[1] - d0 == 1, "R10 single done", done_cnt[1] - d0, 1);
    chk(ld_busy[1] == 1'b0, "R10 busy cleared", int'(ld_busy[1]), 0);

    // R8 promotion of a queued prefetch
    gn = 0;
    push_pf(0, 80);
    push_pf(0, 81);
    push_pf(0, 82);
    push_ld(0, 82);
    wait_n(60);
    chk(glog_addr[1] == 82, "R8 promoted line granted next", glog_addr[1], 82);
    chk(glog_dem[1] == 1, "R8 promoted class flag", glog_dem[1], 1);
    chk(done_cyc[0] == gtime[0][82] + TOTAL + 1, "R8 done timing",
        done_cyc[0], gtime[0][82] + TOTAL + 1);
    chk(gn == 3, "R8 no extra grant", gn, 3);

    // R9 merge with in-flight line
    push_pf(1, 100);
    wait_n(5);
    push_ld(1, 100);
    chk(ld_busy[1] == 1'b1, "R9 busy while waiting", int'(ld_busy[1]), 1);
    wait_n(40);
    chk(gcnt[1][100] == 1, "R9 no second grant", gcnt[1][100], 1);
    chk(done_cyc[1] == gtime[1][100] + TOTAL + 1, "R9 done timing",
        done_cyc[1], gtime[1][100] + TOTAL + 1);

    // R11 load ignored while busy
    d0 = done_cnt[1];
    push_ld(1, 110);
    push_ld(1, 111);
    wait_n(40);
    chk(gcnt[1][111] == 0, "R11 ignored load granted", gcnt[1][111], 0);
    chk(done_cnt[1] - d0 == 1, "R11 done count", done_cnt[1] - d0, 1);

    // R12 load meets its own response
    push_pf(0, 120);
    for (int k = 0; k < 40; k++) begin
      if (rsp_valid && rsp_cpu == 1'b0 && rsp_addr == 8'd120) break;
      tick();
    end
    chk(rsp_valid && rsp_addr == 8'd120, "R12 response seen", int'(rsp_addr), 120);
    push_ld(0, 120);
    chk(ld_done[0] == 1'b1, "R12 immediate done", int'(ld_done[0]), 1);
    chk(ld_busy[0] == 1'b0, "R12 never busy", int'(ld_busy[0]), 0);
    wait_n(30);
    chk(gcnt[0][120] == 1, "R12 no new grant", gcnt[0][120], 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule